// File: doc/BRIEF.md
# Block Copy Repeat Step Unit

This unit carries out one iteration of an 8-bit processor's block-copy instruction. It supports four variants: copying upward or downward, each run either once or repeatedly. A start strobe launches the iteration. The unit reads the accumulator, the byte supplied from memory, the count, destination and source pairs, the address of the instruction and the incoming flags. One clock later it returns the updated pairs, the new program counter, the new flag byte, a scratch-address write with its value, a repeat indication and the number of T-states the iteration took. A one-cycle done pulse marks these results.

The undocumented flag bits 5 and 3 follow the rule observed on real silicon. A single or final iteration takes them from the sum of the accumulator and the copied byte. A repeating iteration overwrites them with bits 13 and 11 of the instruction address, because the program counter is rewound by two. The same rewind also loads the hidden scratch address register with the instruction address plus one.

Top module: `blkcopy_step`

## Requirements
- R1: After reset, `done` is 0 and every result output is 0.
- R2: `done` pulses high for exactly one clock, on the clock after `start` is sampled high. The results stay stable until the next start.
- R3: The count pair always decreases by 1. The source and destination pairs increase by 1 when `dir_down`=0 and decrease by 1 when `dir_down`=1. All of this wraps modulo 65536.
- R4: An iteration repeats (`again`=1) only when `rpt`=1 and the count was not 1 before the decrement.
- R5: On a repeating iteration `pc_out` equals `insn_addr`. Otherwise `pc_out` equals `insn_addr`+2 (modulo 65536).
- R6: Flag bit 2 (parity/overflow) is set exactly when the count was not 1 before the decrement. Bits 4 (half carry) and 1 (subtract) are cleared. Bits 7, 6 and 0 (sign, zero, carry) copy the input flags.
- R7: On a non-repeating iteration, let s = A + data taken modulo 256. Flag bit 5 takes bit 1 of s and flag bit 3 takes bit 3 of s. The final iteration of the repeating form gives the same flags as the single form with the same inputs.
- R8: On a repeating iteration, flag bit 5 takes bit 13 and flag bit 3 takes bit 11 of `insn_addr`. With the instruction at 0x9FFD, 0x9FFE or 0x9FFF this gives bit5=0 and bit3=1. At 0xA000 it gives bit5=1 and bit3=0.
- R9: `tstates` is 21 on a repeating iteration and 16 otherwise.
- R10: On a repeating iteration `mp_we`=1 and `mp_val` is `insn_addr`+1. Otherwise `mp_we`=0 and `mp_val` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one iteration |
| dir_down | input | 1 | 1 selects the decrementing form |
| rpt | input | 1 | 1 selects the repeating form |
| acc | input | 8 | Accumulator |
| data | input | 8 | Byte read from the source |
| bc_in | input | 16 | Count pair |
| de_in | input | 16 | Destination pair |
| hl_in | input | 16 | Source pair |
| insn_addr | input | 16 | Address of the instruction |
| flags_in | input | 8 | Current flag byte |
| bc_out | output | 16 | Updated count |
| de_out | output | 16 | Updated destination |
| hl_out | output | 16 | Updated source |
| pc_out | output | 16 | Next program counter |
| flags_out | output | 8 | New flag byte |
| mp_we | output | 1 | Scratch address register write enable |
| mp_val | output | 16 | Scratch address register value |
| again | output | 1 | Iteration repeats |
| tstates | output | 5 | T-states used |
| done | output | 1 | Result valid pulse |

## Verification
The bench drives single iterations upward and downward with counts of 1 and larger. This separates the sum-derived flag bits from the address-derived ones and checks the direction of the pointer steps. The repeating form is run with a count of 1 and with a count of 0, which wraps to 0xFFFF. These runs show that only a pre-decrement count of 1 ends the loop. The four instruction addresses around 0xA000 check the bit 13/bit 11 pick-up. Source and destination values of 0xFFFF and 0x0000 check wrap-around, and sign, zero and carry patterns on the input flags check that those bits pass through.

// File: rtl/blkcopy_step.sv
module blkcopy_step #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_down,
  input  logic          rpt,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] data,
  input  logic [AW-1:0] bc_in,
  input  logic [AW-1:0] de_in,
  input  logic [AW-1:0] hl_in,
  input  logic [AW-1:0] insn_addr,
  input  logic [DW-1:0] flags_in,
  output logic [AW-1:0] bc_out,
  output logic [AW-1:0] de_out,
  output logic [AW-1:0] hl_out,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] flags_out,
  output logic          mp_we,
  output logic [AW-1:0] mp_val,
  output logic          again,
  output logic [4:0]    tstates,
  output logic          done
);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [4:0] T_LOOP = 5'd21;
  localparam logic [4:0] T_LAST = 5'd16;

  logic          cnt_live;
  logic          loop_c;
  logic [AW-1:0] step;
  logic [DW-1:0] sum;
  logic          yf, xf;
  logic [DW-1:0] f_next;

  assign cnt_live = (bc_in != ONE);
  assign loop_c   = rpt & cnt_live;
  assign step     = dir_down ? {AW{1'b1}} : ONE;
  assign sum      = acc + data;
  assign yf       = loop_c ? insn_addr[13] : sum[1];
  assign xf       = loop_c ? insn_addr[11] : sum[3];
  assign f_next   = {flags_in[7], flags_in[6], yf, 1'b0, xf, cnt_live, 1'b0, flags_in[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_out    <= '0;
      de_out    <= '0;
      hl_out    <= '0;
      pc_out    <= '0;
      flags_out <= '0;
      mp_we     <= 1'b0;
      mp_val    <= '0;
      again     <= 1'b0;
      tstates   <= '0;
      done      <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        bc_out    <= bc_in - ONE;
        de_out    <= de_in + step;
        hl_out    <= hl_in + step;
        pc_out    <= loop_c ? insn_addr : insn_addr + AW'(2);
        flags_out <= f_next;
        mp_we     <= loop_c;
        mp_val    <= loop_c ? insn_addr + ONE : '0;
        again     <= loop_c;
        tstates   <= loop_c ? T_LOOP : T_LAST;
      end
    end
  end
endmodule

module blkcopy_step_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        done,
  input logic        again,
  input logic        mp_we,
  input logic [4:0]  tstates,
  input logic [7:0]  flags_out,
  input logic [15:0] pc_out,
  input logic [15:0] mp_val
);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(start)) |-> 1'b0) else $error("done without start");
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(pc_out) && $stable(flags_out));
  assert_tstate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tstates == (again ? 5'd21 : 5'd16)));
  assert_memptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mp_we == again) && (!again || mp_val == pc_out + 16'd1));
  assert_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags_out[4] == 1'b0 && flags_out[1] == 1'b0));
  assert_pv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && again) |-> flags_out[2]);
endmodule

bind blkcopy_step blkcopy_step_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .again(again),
  .mp_we(mp_we), .tstates(tstates), .flags_out(flags_out),
  .pc_out(pc_out), .mp_val(mp_val)
);

// File: tb/test_blkcopy_step.sv
module test_blkcopy_step;
  logic clk = 0, rst_n = 0, start = 0, dir_down = 0, rpt = 0;
  logic [7:0] acc = 0, data = 0, flags_in = 0;
  logic [15:0] bc_in = 0, de_in = 0, hl_in = 0, insn_addr = 0;
  logic [15:0] bc_out, de_out, hl_out, pc_out, mp_val;
  logic [7:0] flags_out;
  logic mp_we, again, done;
  logic [4:0] tstates;
  int tests = 0, fails = 0;

  typedef struct packed {
    logic [15:0] bc, de, hl, pc, mp;
    logic [7:0]  f;
    logic        we, ag;
    logic [4:0]  t;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  blkcopy_step i_blkcopy_step (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic dn, input logic rp, input logic [7:0] a, input logic [7:0] d,
                       input logic [15:0] bc, input logic [15:0] de, input logic [15:0] hl,
                       input logic [15:0] pc, input logic [7:0] f);
    exp_t e;
    logic lp, live;
    logic [7:0] s;
    logic [15:0] st;
    live = (bc != 16'd1);
    lp = rp && live;
    s = a + d;
    st = dn ? 16'hFFFF : 16'h0001;
    e.bc = bc - 16'd1; e.de = de + st; e.hl = hl + st;
    e.pc = lp ? pc : pc + 16'd2;
    e.mp = lp ? pc + 16'd1 : 16'd0;
    e.we = lp; e.ag = lp; e.t = lp ? 5'd21 : 5'd16;
    e.f = {f[7], f[6], lp ? pc[13] : s[1], 1'b0, lp ? pc[11] : s[3], live, 1'b0, f[0]};
    q.push_back(e);
    @(negedge clk);
    dir_down = dn; rpt = rp; acc = a; data = d; bc_in = bc; de_in = de; hl_in = hl;
    insn_addr = pc; flags_in = f; start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n && done) begin
    exp_t e;
    if (q.size() == 0) begin chk("R2", 1, 0); end
    else begin
      e = q.pop_front();
      chk("R3", {bc_out, de_out}, {e.bc, e.de});
      chk("R3", hl_out, e.hl);
      chk("R4", again, e.ag);
      chk("R5", pc_out, e.pc);
      chk("R6 R7 R8", flags_out, e.f);
      chk("R9", tstates, e.t);
      chk("R10", {mp_we, mp_val}, {e.we, e.mp});
    end
  end

  initial begin
    #2000000;
    fails++; tests++;
    $display("FAIL watchdog");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {done, again, mp_we, tstates}, 0);
    chk("R1", {bc_out, pc_out, flags_out}, 0);
    rst_n = 1;
    drive(0, 0, 8'h38, 8'h38, 16'h0010, 16'hC000, 16'hD000, 16'h0E82, 8'hC1);
    drive(1, 0, 8'h05, 8'h03, 16'h0001, 16'h0000, 16'h0000, 16'h1234, 8'h00);
    drive(0, 1, 8'h38, 8'h38, 16'h00B0, 16'h5A50, 16'h5A4F, 16'h9FFD, 8'h40);
    chk("R8", {flags_out[5], flags_out[3]}, 2'b01);
    drive(0, 1, 8'h00, 8'h00, 16'h0002, 16'h0, 16'h0, 16'h9FFE, 8'h00);
    drive(1, 1, 8'h00, 8'h00, 16'h0002, 16'h0, 16'h0, 16'h9FFF, 8'h00);
    chk("R8", {flags_out[5], flags_out[3]}, 2'b01);
    drive(0, 1, 8'hFF, 8'hFF, 16'h0005, 16'hFFFF, 16'hFFFF, 16'hA000, 8'h81);
    chk("R8", {flags_out[5], flags_out[3]}, 2'b10);
    drive(0, 1, 8'h02, 8'h08, 16'h0001, 16'h1, 16'h2, 16'hFFFF, 8'hFF);
    chk("R7", {again, flags_out[5], flags_out[3]}, 3'b011);
    drive(0, 1, 8'h00, 8'h00, 16'h0000, 16'h1, 16'h2, 16'h2800, 8'h00);
    chk("R4", bc_out, 16'hFFFF);
    repeat (3) @(negedge clk);
    chk("R2", done, 0);
    chk("R1", q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule